// File: doc/BRIEF.md
# Instruction Repeat-Expansion Sequencer

This block sits between instruction decode and issue. It accepts one 32-bit instruction at a time, together with a repeat length and a per-element predicate mask. It then emits a run of copies of that instruction in element order, one per cycle. In copy number i, every register field that the instruction's format actually uses is advanced by i. A run of contiguous register operations can therefore be written as a single instruction.

Some instructions are never repeated. These are the upper-immediate forms, system and fence instructions, load-reserved and store-conditional, and anything in the 16-bit encoding space. They leave exactly once and unchanged. The predicate mask can be complemented by a control bit, and elements whose effective bit is clear are skipped without spending a cycle.

Both sides use valid/ready handshakes. The length, mask and invert controls are sampled on the cycle the instruction is accepted.

Top module: `repeat_expander`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: An expandable instruction accepted with length L and all elements enabled produces L copies in increasing element order. In copy i, each used register field that is not x0 equals (base + i) mod 32, and all other bits are unchanged. The fields are rd [11:7], rs1 [19:15], rs2 [24:20] and rs3 [31:27]. Field use by opcode: 0110011, 0111011, 1010011 and 0101111 use rd, rs1 and rs2. 0010011, 0011011, 0000011, 0000111 and 1100111 use rd and rs1. 0100011, 0100111 and 1100011 use rs1 and rs2. 1101111 uses rd. 1000011, 1000111, 1001011 and 1001111 use all four. Any other opcode uses no field.
- R3: A used register field equal to x0 (value 0) stays 0 in every copy.
- R4: The following are emitted exactly once, bit-identical to the input, whatever the length and predicate: any instruction whose bits [1:0] are not 11, and opcodes (bits [6:0]) 0110111, 0010111, 1110011 and 0001111.
- R5: For opcode 0101111, funct5 (bits [31:27]) of 00010 or 00011 is treated as scalar under R4. Every other funct5 is expanded under R2.
- R6: Element i of an expandable instruction is emitted only when bit i of the effective mask is 1. The effective mask is the mask input, or its bitwise complement when the invert input is 1.
- R7: An expandable instruction with no enabled element produces no output, is still accepted, and inReady is 1 in the cycle after its acceptance.
- R8: The length is sampled at acceptance. A value of 0 acts as 1, and a value above 8 acts as 8. With length 1 and element 0 enabled, the single copy equals the input.
- R9: While outValid is 1 and outReady is 0, outValid stays 1 and outInsn stays unchanged into the next cycle.
- R10: inReady is 0 from the cycle after an instruction with output is accepted until the cycle after its last copy is accepted. Copies of two instructions never interleave.
- R11: The first copy appears as outValid in the cycle after acceptance. Each further enabled copy follows in the cycle after the previous one is accepted, and skipped elements take no cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input instruction valid |
| inReady | output | 1 | Block can accept an instruction |
| inInsn | input | 32 | Instruction to expand |
| cfgLen | input | 4 | Repeat length, sampled at acceptance |
| cfgMask | input | 8 | Predicate mask, bit i for element i |
| cfgInvert | input | 1 | Complement the predicate mask |
| outValid | output | 1 | Output copy valid |
| outReady | input | 1 | Downstream accepts the copy |
| outInsn | output | 32 | Emitted instruction copy |

## Verification
The first copy of each instruction is due one cycle after the accepting edge. The driver checks at the next falling edge that outValid is then high, or, when every element is masked, that inReady is already back. Each later copy is due one cycle after the edge that accepted its predecessor. The monitor therefore compares at every falling edge where outValid and the outReady it has just set will complete a transfer at the coming edge, and it also checks that a stalled copy is still present and unchanged one cycle later. Expected copies are built by a separate model of the classification, the mask and the renumbering, and queued ahead of each acceptance.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int INSN_W = 32;
  localparam int REG_W  = 5;

  localparam logic [6:0] OPC_LUI      = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC    = 7'b0010111;
  localparam logic [6:0] OPC_SYSTEM   = 7'b1110011;
  localparam logic [6:0] OPC_MISCMEM  = 7'b0001111;
  localparam logic [6:0] OPC_AMO      = 7'b0101111;
  localparam logic [6:0] OPC_OP       = 7'b0110011;
  localparam logic [6:0] OPC_OP32     = 7'b0111011;
  localparam logic [6:0] OPC_OPFP     = 7'b1010011;
  localparam logic [6:0] OPC_OPIMM    = 7'b0010011;
  localparam logic [6:0] OPC_OPIMM32  = 7'b0011011;
  localparam logic [6:0] OPC_LOAD     = 7'b0000011;
  localparam logic [6:0] OPC_LOADFP   = 7'b0000111;
  localparam logic [6:0] OPC_JALR     = 7'b1100111;
  localparam logic [6:0] OPC_STORE    = 7'b0100011;
  localparam logic [6:0] OPC_STOREFP  = 7'b0100111;
  localparam logic [6:0] OPC_BRANCH   = 7'b1100011;
  localparam logic [6:0] OPC_JAL      = 7'b1101111;
  localparam logic [6:0] OPC_FMADD    = 7'b1000011;
  localparam logic [6:0] OPC_FMSUB    = 7'b1000111;
  localparam logic [6:0] OPC_FNMSUB   = 7'b1001011;
  localparam logic [6:0] OPC_FNMADD   = 7'b1001111;

  localparam logic [4:0] AMO_F5_LR = 5'b00010;
  localparam logic [4:0] AMO_F5_SC = 5'b00011;

  // Classification of one instruction: scalar pass-through plus field usage
  typedef struct packed {
    logic scalar;
    logic useRd;
    logic useRs1;
    logic useRs2;
    logic useRs3;
  } insnClass_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } ctrlStrobe_t;

  function automatic logic [REG_W-1:0] bumpReg(input logic [REG_W-1:0] base,
                                                input logic [REG_W-1:0] step);
    return (base == '0) ? '0 : base + step;
  endfunction
endpackage

// File: rtl/rx_classify.sv
module rx_classify
  import rx_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output insnClass_t        cls
);
  logic [6:0] opcode;
  logic [4:0] funct5;
  logic       wide;

  assign opcode = insn[6:0];
  assign funct5 = insn[31:27];
  assign wide   = (insn[1:0] == 2'b11);

  always_comb begin
    cls = '0;
    if (!wide) begin
      cls.scalar = 1'b1;
    end else begin
      unique case (opcode)
        OPC_LUI, OPC_AUIPC, OPC_SYSTEM, OPC_MISCMEM: cls.scalar = 1'b1;
        OPC_AMO: begin
          if (funct5 == AMO_F5_LR || funct5 == AMO_F5_SC) begin
            cls.scalar = 1'b1;
          end else begin
            cls.useRd  = 1'b1;
            cls.useRs1 = 1'b1;
            cls.useRs2 = 1'b1;
          end
        end
        OPC_OP, OPC_OP32, OPC_OPFP: begin
          cls.useRd  = 1'b1;
          cls.useRs1 = 1'b1;
          cls.useRs2 = 1'b1;
        end
        OPC_OPIMM, OPC_OPIMM32, OPC_LOAD, OPC_LOADFP, OPC_JALR: begin
          cls.useRd  = 1'b1;
          cls.useRs1 = 1'b1;
        end
        OPC_STORE, OPC_STOREFP, OPC_BRANCH: begin
          cls.useRs1 = 1'b1;
          cls.useRs2 = 1'b1;
        end
        OPC_JAL: cls.useRd = 1'b1;
        OPC_FMADD, OPC_FMSUB, OPC_FNMSUB, OPC_FNMADD: begin
          cls.useRd  = 1'b1;
          cls.useRs1 = 1'b1;
          cls.useRs2 = 1'b1;
          cls.useRs3 = 1'b1;
        end
        default: cls = '0;
      endcase
    end
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [INSN_W-1:0]  inInsn,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic [MAX_LEN-1:0] cfgMask,
  input  logic               cfgInvert,
  output logic               anyEnabled,
  output logic               lastElem,
  output logic [INSN_W-1:0]  outInsn
);
  localparam int IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  insnClass_t         inCls;
  insnClass_t         heldCls;
  logic [INSN_W-1:0]  heldInsn;
  logic [MAX_LEN-1:0] pend;
  logic [MAX_LEN-1:0] lenMask;
  logic [MAX_LEN-1:0] effMask;
  logic [MAX_LEN-1:0] loadMask;
  logic [LEN_W-1:0]   clampLen;
  logic [IDX_W-1:0]   curIdx;
  logic [REG_W-1:0]   step;

  rx_classify i_classify (
    .insn (inInsn),
    .cls  (inCls)
  );

  // Length limited to 1..MAX_LEN
  always_comb begin
    if (cfgLen == '0)                     clampLen = LEN_W'(1);
    else if (cfgLen > LEN_W'(MAX_LEN))    clampLen = LEN_W'(MAX_LEN);
    else                                  clampLen = cfgLen;
  end

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_lenMask
    assign lenMask[g] = (LEN_W'(g) < clampLen);
  end

  assign effMask    = (cfgInvert ? ~cfgMask : cfgMask) & lenMask;
  assign loadMask   = inCls.scalar ? MAX_LEN'(1) : effMask;
  assign anyEnabled = |loadMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldInsn <= '0;
      heldCls  <= '0;
      pend     <= '0;
    end else if (strobe.load) begin
      heldInsn <= inInsn;
      heldCls  <= inCls;
      pend     <= loadMask;
    end else if (strobe.advance) begin
      pend     <= pend & (pend - MAX_LEN'(1));
    end
  end

  // Lowest pending element is the one on the output
  always_comb begin
    curIdx = '0;
    for (int k = MAX_LEN - 1; k >= 0; k--) begin
      if (pend[k]) curIdx = IDX_W'(k);
    end
  end

  assign lastElem = ((pend & (pend - MAX_LEN'(1))) == '0);
  assign step     = REG_W'(curIdx);

  always_comb begin
    outInsn = heldInsn;
    if (heldCls.useRd)  outInsn[11:7]  = bumpReg(heldInsn[11:7],  step);
    if (heldCls.useRs1) outInsn[19:15] = bumpReg(heldInsn[19:15], step);
    if (heldCls.useRs2) outInsn[24:20] = bumpReg(heldInsn[24:20], step);
    if (heldCls.useRs3) outInsn[31:27] = bumpReg(heldInsn[31:27], step);
  end
endmodule

// File: rtl/rx_control.sv
module rx_control
  import rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  logic        anyEnabled,
  input  logic        lastElem,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_EMIT} state_t;
  state_t state, stateNext;

  assign inReady        = (state == ST_IDLE);
  assign outValid       = (state == ST_EMIT);
  assign strobe.load    = inValid && inReady;
  assign strobe.advance = outValid && outReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobe.load && anyEnabled) stateNext = ST_EMIT;
      ST_EMIT: if (strobe.advance && lastElem) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/repeat_expander.sv
module repeat_expander
  import rx_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [31:0]        inInsn,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic [MAX_LEN-1:0] cfgMask,
  input  logic               cfgInvert,
  output logic               outValid,
  input  logic               outReady,
  output logic [31:0]        outInsn
);
  ctrlStrobe_t strobe;
  logic        anyEnabled;
  logic        lastElem;

  rx_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .outReady   (outReady),
    .anyEnabled (anyEnabled),
    .lastElem   (lastElem),
    .inReady    (inReady),
    .outValid   (outValid),
    .strobe     (strobe)
  );

  rx_datapath #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inInsn     (inInsn),
    .cfgLen     (cfgLen),
    .cfgMask    (cfgMask),
    .cfgInvert  (cfgInvert),
    .anyEnabled (anyEnabled),
    .lastElem   (lastElem),
    .outInsn    (outInsn)
  );
endmodule

// File: rtl/rx_checker.sv
module rx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic [31:0] inInsn,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outInsn
);
  // R9: a stalled copy stays put
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outInsn)));

  // R10: no new acceptance while copies are pending
  a_r10_no_accept_while_emitting: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R10: ready returns only after the final copy was taken
  a_r10_ready_after_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> $past(outValid && outReady));

  // R4 / R11: an upper-immediate load leaves unchanged on the next cycle
  a_r4_lui_unchanged: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inInsn[6:0] == 7'b0110111) |=>
      (outValid && outInsn == $past(inInsn)));
endmodule

bind repeat_expander rx_checker i_rx_checker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inInsn   (inInsn),
  .outValid (outValid),
  .outReady (outReady),
  .outInsn  (outInsn)
);

// File: tb/test_repeat_expander.sv
module test_repeat_expander;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inInsn = '0;
  logic [3:0]  cfgLen = 4'd1;
  logic [7:0]  cfgMask = 8'hff;
  logic        cfgInvert = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outInsn;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit readyRandom = 1'b0;
  logic [15:0] lfsr = 16'hace1;
  bit prevStall = 1'b0;
  logic [31:0] prevInsn = '0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  repeat_expander i_repeat_expander (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inInsn(inInsn),
    .cfgLen(cfgLen), .cfgMask(cfgMask), .cfgInvert(cfgInvert),
    .outValid(outValid), .outReady(outReady), .outInsn(outInsn));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model: scalar test
  function automatic bit tbScalar(input logic [31:0] x);
    if (x[1:0] != 2'b11) return 1'b1;
    case (x[6:0])
      7'b0110111, 7'b0010111, 7'b1110011, 7'b0001111: return 1'b1;
      7'b0101111: return (x[31:27] == 5'b00010) || (x[31:27] == 5'b00011);
      default: return 1'b0;
    endcase
  endfunction

  // Independent model: fields used, as {rs3, rs2, rs1, rd}
  function automatic logic [3:0] tbFields(input logic [31:0] x);
    case (x[6:0])
      7'b0110011, 7'b0111011, 7'b1010011, 7'b0101111: return 4'b0111;
      7'b0010011, 7'b0011011, 7'b0000011, 7'b0000111, 7'b1100111: return 4'b0011;
      7'b0100011, 7'b0100111, 7'b1100011: return 4'b0110;
      7'b1101111: return 4'b0001;
      7'b1000011, 7'b1000111, 7'b1001011, 7'b1001111: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [4:0] tbBump(input logic [4:0] r, input int i);
    logic [4:0] s;
    s = 5'(i);
    if (r == 5'd0) return 5'd0;
    return 5'((int'(r) + int'(s)) % 32);
  endfunction

  function automatic logic [31:0] tbCopy(input logic [31:0] x, input int i);
    logic [3:0] f;
    logic [31:0] y;
    f = tbFields(x);
    y = x;
    if (f[0]) y[11:7]  = tbBump(x[11:7], i);
    if (f[1]) y[19:15] = tbBump(x[19:15], i);
    if (f[2]) y[24:20] = tbBump(x[24:20], i);
    if (f[3]) y[31:27] = tbBump(x[31:27], i);
    return y;
  endfunction

  // Driver: queue expected copies, then hand the instruction over
  task automatic send(input logic [31:0] x, input logic [3:0] len, input logic [7:0] mask,
                      input bit inv, input string tag);
    int n;
    int effLen;
    logic [7:0] em;
    n = 0;
    effLen = (len == 0) ? 1 : ((len > 8) ? 8 : int'(len));
    em = inv ? ~mask : mask;
    if (tbScalar(x)) begin
      expQ.push_back(x); tagQ.push_back(tag); n = 1;
    end else begin
      for (int i = 0; i < effLen; i++) begin
        if (em[i]) begin
          expQ.push_back(tbCopy(x, i)); tagQ.push_back(tag); n++;
        end
      end
    end
    do @(negedge clk); while (!inReady);
    inInsn = x; cfgLen = len; cfgMask = mask; cfgInvert = inv; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    if (n > 0) chk(outValid == 1'b1, {"R11 first copy next cycle ", tag}, 32'(outValid), 32'd1);
    else       chk(inReady == 1'b1 && outValid == 1'b0, "R7 all masked accepted", 32'(inReady), 32'd1);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (readyRandom) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        outReady = lfsr[0] | lfsr[3];
      end else begin
        outReady = 1'b1;
      end
      if (prevStall)
        chk(outValid && outInsn == prevInsn, "R9 stalled copy held", outInsn, prevInsn);
      if (outValid)
        chk(!inReady, "R10 inReady low while emitting", 32'(inReady), 32'd0);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R10 unexpected copy", outInsn, 32'hxxxxxxxx);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(outInsn == e, t, outInsn, e);
        end
      end
      prevStall = outValid && !outReady;
      prevInsn  = outInsn;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1 reset outValid", 32'(outValid), 32'd0);
    chk(inReady == 1'b1, "R1 reset inReady", 32'(inReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);

    // R2: register form, length 4
    send(rtype(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), 4'd4, 8'hff, 1'b0, "R2 add len4");
    // R3: immediate form with rs1 = x0; immediate bits untouched
    send({12'h7f5, 5'd0, 3'b000, 5'd9, 7'b0010011}, 4'd3, 8'hff, 1'b0, "R3 addi x0 source");
    // R2: store keeps immediate in rd slot
    send({7'h01, 5'd4, 5'd8, 3'b010, 5'd17, 7'b0100011}, 4'd2, 8'hff, 1'b0, "R2 store");
    // R2: wrap modulo 32
    send(rtype(7'h00, 5'd31, 5'd29, 3'b000, 5'd30, 7'b0110011), 4'd3, 8'hff, 1'b0, "R2 wrap");
    // R2: four-operand form
    send({5'd10, 2'b00, 5'd6, 5'd5, 3'b000, 5'd4, 7'b1000011}, 4'd2, 8'hff, 1'b0, "R2 fused four fields");
    // R4: scalar set
    send({20'h12345, 5'd7, 7'b0110111}, 4'd8, 8'hff, 1'b0, "R4 lui once");
    send({20'h00abc, 5'd7, 7'b0010111}, 4'd5, 8'h00, 1'b0, "R4 auipc once");
    send(32'h1050_0073, 4'd6, 8'hff, 1'b0, "R4 wfi once");
    send(32'h0010_0073, 4'd6, 8'hff, 1'b0, "R4 ebreak once");
    send(32'h0ff0_000f, 4'd7, 8'hff, 1'b0, "R4 fence once");
    send(32'h0000_a001, 4'd8, 8'hff, 1'b0, "R4 compressed jump once");
    send(32'h0000_8082, 4'd8, 8'hff, 1'b0, "R4 compressed reg jump once");
    // R5: reserve/conditional scalar, other atomics expand
    send({5'b00010, 2'b00, 5'd0, 5'd10, 3'b010, 5'd5, 7'b0101111}, 4'd4, 8'hff, 1'b0, "R5 lr once");
    send({5'b00011, 2'b00, 5'd6, 5'd10, 3'b010, 5'd5, 7'b0101111}, 4'd4, 8'hff, 1'b0, "R5 sc once");
    send({5'b00001, 2'b00, 5'd6, 5'd10, 3'b010, 5'd5, 7'b0101111}, 4'd3, 8'hff, 1'b0, "R5 amoswap expands");
    send({5'b10100, 2'b00, 5'd6, 5'd10, 3'b010, 5'd5, 7'b0101111}, 4'd2, 8'hff, 1'b0, "R5 amomax expands");
    // R6: predicate and inversion
    send(rtype(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), 4'd8, 8'b1010_0101, 1'b0, "R6 mask");
    send(rtype(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), 4'd8, 8'b1010_0101, 1'b1, "R6 inverted mask");
    // R7: nothing enabled
    send(rtype(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), 4'd4, 8'h00, 1'b0, "R7 all masked");
    send(rtype(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), 4'd4, 8'hf0, 1'b0, "R7 masked within length");
    // R8: length clamping
    send(rtype(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), 4'd0, 8'hff, 1'b0, "R8 length zero");
    send(rtype(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011), 4'd15, 8'hff, 1'b0, "R8 length above max");
    send({12'h001, 5'd4, 3'b000, 5'd4, 7'b0010011}, 4'd1, 8'h01, 1'b0, "R8 length one unchanged");
    // R9, R10: random back-pressure
    readyRandom = 1'b1;
    for (int k = 0; k < 12; k++) begin
      send(rtype(7'h20, 5'(k), 5'(k + 3), 3'b000, 5'(k + 1), 7'b0110011), 4'(k % 9), 8'(8'h5b ^ 8'(k * 37)),
           1'(k % 2), "R9 back-pressure run");
    end
    send({5'b10100, 2'b00, 5'd6, 5'd10, 3'b010, 5'd5, 7'b0101111}, 4'd8, 8'hff, 1'b0, "R10 atomic under stall");

    for (int w = 0; w < 200 && (expQ.size() != 0 || !inReady); w++) @(negedge clk);
    chk(expQ.size() == 0, "R10 all expected copies seen", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule